// File: doc/BRIEF.md
# Serial Configuration Loader

This block is the receiving end of a bit-serial configuration link. It captures a configuration bitstream into an internal frame buffer, one bit for each configuration clock. The configuration clock has two possible sources. In the externally clocked mode a source outside the block drives it. In the self-clocked mode the block makes its own clock with a programmable divider. That divider always comes out of reset at its slowest rate, and software can raise the rate later.

Each device is given a bit length. When it has captured that many bits, a sticky done flag goes high. From then on every further incoming bit is passed to a chain output. Several loaders can therefore be wired in series and fed from one serial source: each device takes its own share of the stream and hands the rest to the next device. The operating mode and the length are sampled once, on the first clock after reset is released. Everything runs on the system clock `clk`. In the externally clocked mode the configuration clock and the data are resynchronised before use.

Top module: `cfg_serial_loader`

## Requirements
- R1: While reset is asserted and directly after it, `done`, `dout`, `cclk_out`, `bit_count` and `frame_data` are all zero.
- R2: `mode_sel` is sampled on the first `clk` edge after reset release. 3'b111 selects the externally clocked mode and 3'b000 selects the self-clocked mode. Later changes of `mode_sel` have no effect until the next reset.
- R3: In the externally clocked mode, a rising edge of `cclk_in` captures `din` after both signals pass a two-stage synchroniser. The k-th captured bit (k counted from 0) is written to `frame_data[k]`, and `bit_count` counts the captured bits. `cclk_out` stays low.
- R4: In the self-clocked mode, `cclk_out` has a high phase and a low phase of 2^(3-r) `clk` cycles each, where r is the active rate code. After reset r is 0, which gives 8-cycle phases, the slowest setting. `din` is captured on the `clk` edge at which `cclk_out` rises.
- R5: A pulse on `rate_wr` stores `rate_code` as a pending rate. The pending rate becomes active only at the next rising edge of `cclk_out`. The low phase that is in progress when the pulse arrives finishes at the old length. Within any one period the high phase and the low phase have the same length.
- R6: `cfg_len` is sampled together with `mode_sel`. A value above the frame size (32) is clamped to the frame size.
- R7: `done` rises on the same edge that captures the bit which brings `bit_count` up to the length. It stays high until reset.
- R8: Once `done` is high, `frame_data` and `bit_count` no longer change. Each further captured bit appears on `dout` at its capture edge and is held there until the next bit arrives. Before `done`, `dout` is 0.
- R9: Any other `mode_sel` code selects idle. No bits are captured and `cclk_out` stays low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| mode_sel | input | 3 | Mode code, sampled after reset |
| cfg_len | input | 6 | Bit length owned by this device, sampled after reset |
| rate_code | input | 2 | Requested self-clocked rate (0 = slowest) |
| rate_wr | input | 1 | Loads `rate_code` into the pending rate register |
| cclk_in | input | 1 | External configuration clock |
| din | input | 1 | Serial configuration data |
| cclk_out | output | 1 | Generated configuration clock (self-clocked mode) |
| dout | output | 1 | Chain output toward the next device |
| done | output | 1 | Own share of the stream fully captured |
| frame_data | output | 32 | Captured frame, first bit in bit 0 |
| bit_count | output | 6 | Number of bits captured |

## Verification
The bench feeds random bit streams and targets the boundary at the length. If the count is off by one, `done` rises one bit early or one bit late, and a chain bit either lands in the frame or is lost. A rate request is issued in the middle of a low phase. A design that switches the rate at once produces a short, mismatched low phase, and the bench measures that phase directly. It also checks that the first period runs at the slowest rate. The bench changes `mode_sel` after reset, applies an oversized length and applies an idle code. A loader that re-samples the mode, skips the clamp or wrongly accepts bits in idle will show a wrong clock output, a wrong count or a wrong done flag.

// File: rtl/cfg_loader_pkg.sv
package cfg_loader_pkg;

  typedef enum logic [1:0] {
    LD_IDLE   = 2'd0,
    LD_EXTCLK = 2'd1,
    LD_SELFCLK = 2'd2
  } ld_mode_e;

  localparam logic [2:0] MODE_CODE_EXT  = 3'b111;
  localparam logic [2:0] MODE_CODE_SELF = 3'b000;

  function automatic ld_mode_e decode_mode(input logic [2:0] code);
    ld_mode_e m;
    case (code)
      MODE_CODE_EXT:  m = LD_EXTCLK;
      MODE_CODE_SELF: m = LD_SELFCLK;
      default:        m = LD_IDLE;
    endcase
    return m;
  endfunction

endpackage

// File: rtl/cfg_mode_latch.sv
module cfg_mode_latch
  import cfg_loader_pkg::*;
#(
  parameter int FRAME_BITS = 32,
  parameter int LEN_W      = 6
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [2:0]       mode_sel,
  input  logic [LEN_W-1:0] cfg_len,
  output logic             armed,
  output ld_mode_e         mode,
  output logic [LEN_W-1:0] len
);

  logic             armed_q, armed_d;
  ld_mode_e         mode_q, mode_d;
  logic [LEN_W-1:0] len_q, len_d;

  // Capture happens exactly once: on the first edge with reset released.
  always_comb begin
    armed_d = armed_q;
    mode_d  = mode_q;
    len_d   = len_q;
    if (!armed_q) begin
      armed_d = 1'b1;
      mode_d  = decode_mode(mode_sel);
      len_d   = (cfg_len > LEN_W'(FRAME_BITS)) ? LEN_W'(FRAME_BITS) : cfg_len;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      armed_q <= 1'b0;
      mode_q  <= LD_IDLE;
      len_q   <= '0;
    end else begin
      armed_q <= armed_d;
      mode_q  <= mode_d;
      len_q   <= len_d;
    end
  end

  assign armed = armed_q;
  assign mode  = mode_q;
  assign len   = len_q;

endmodule

// File: rtl/cfg_clk_div.sv
module cfg_clk_div #(
  parameter int RATE_W         = 2,
  parameter int BASE_HALF_LOG2 = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              en,
  input  logic [RATE_W-1:0] rate_code,
  input  logic              rate_wr,
  output logic              cclk_out,
  output logic              rise
);

  localparam int CNT_W = BASE_HALF_LOG2 + 1;

  logic [RATE_W-1:0] rate_pend_q, rate_pend_d;
  logic [RATE_W-1:0] rate_act_q, rate_act_d;
  logic [CNT_W-1:0]  cnt_q, cnt_d;
  logic              cclk_q, cclk_d;
  logic [CNT_W-1:0]  half_m1;
  logic              phase_end;

  // Phase length minus one for the active rate; faster codes saturate at 1 cycle.
  always_comb begin
    if (int'(rate_act_q) >= BASE_HALF_LOG2)
      half_m1 = '0;
    else
      half_m1 = (CNT_W'(1) << (BASE_HALF_LOG2 - int'(rate_act_q))) - CNT_W'(1);
  end

  assign phase_end = en && (cnt_q == half_m1);

  always_comb begin
    rate_pend_d = rate_wr ? rate_code : rate_pend_q;
    rate_act_d  = rate_act_q;
    cnt_d       = cnt_q;
    cclk_d      = cclk_q;
    if (!en) begin
      cnt_d  = '0;
      cclk_d = 1'b0;
    end else if (phase_end) begin
      cnt_d  = '0;
      cclk_d = !cclk_q;
      // The period boundary is the low-to-high transition; switch rate only there.
      if (!cclk_q) rate_act_d = rate_pend_q;
    end else begin
      cnt_d = cnt_q + CNT_W'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rate_pend_q <= '0;
      rate_act_q  <= '0;
      cnt_q       <= '0;
      cclk_q      <= 1'b0;
    end else begin
      rate_pend_q <= rate_pend_d;
      rate_act_q  <= rate_act_d;
      cnt_q       <= cnt_d;
      cclk_q      <= cclk_d;
    end
  end

  assign cclk_out = cclk_q;
  assign rise     = phase_end && !cclk_q;

endmodule

// File: rtl/cfg_ext_sync.sv
module cfg_ext_sync #(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic cclk_in,
  input  logic din,
  output logic strobe,
  output logic bit_out
);

  logic [SYNC_STAGES-1:0] clk_pipe_q;
  logic [SYNC_STAGES-1:0] dat_pipe_q;
  logic                   clk_last_q;

  genvar g;
  generate
    for (g = 0; g < SYNC_STAGES; g++) begin : g_stage
      logic clk_src, dat_src;
      if (g == 0) begin : g_first
        assign clk_src = cclk_in;
        assign dat_src = din;
      end else begin : g_next
        assign clk_src = clk_pipe_q[g-1];
        assign dat_src = dat_pipe_q[g-1];
      end
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          clk_pipe_q[g] <= 1'b0;
          dat_pipe_q[g] <= 1'b0;
        end else begin
          clk_pipe_q[g] <= clk_src;
          dat_pipe_q[g] <= dat_src;
        end
      end
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) clk_last_q <= 1'b0;
    else        clk_last_q <= clk_pipe_q[SYNC_STAGES-1];
  end

  assign strobe  = clk_pipe_q[SYNC_STAGES-1] && !clk_last_q;
  assign bit_out = dat_pipe_q[SYNC_STAGES-1];

endmodule

// File: rtl/cfg_frame_capture.sv
module cfg_frame_capture #(
  parameter int FRAME_BITS = 32,
  parameter int LEN_W      = 6
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  en,
  input  logic                  strobe,
  input  logic                  bit_in,
  input  logic [LEN_W-1:0]      len,
  output logic [FRAME_BITS-1:0] frame,
  output logic [LEN_W-1:0]      count,
  output logic                  done,
  output logic                  dout
);

  logic [LEN_W-1:0] cnt_q, cnt_d;
  logic             done_q, done_d;
  logic             dout_q, dout_d;
  logic             take;

  assign take = strobe && !done_q;

  always_comb begin
    cnt_d  = take ? cnt_q + LEN_W'(1) : cnt_q;
    done_d = done_q || (en && (cnt_d == len));
    dout_d = (strobe && done_q) ? bit_in : dout_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q  <= '0;
      done_q <= 1'b0;
      dout_q <= 1'b0;
    end else begin
      cnt_q  <= cnt_d;
      done_q <= done_d;
      dout_q <= dout_d;
    end
  end

  genvar i;
  generate
    for (i = 0; i < FRAME_BITS; i++) begin : g_cell
      logic cell_q;
      logic cell_we;
      assign cell_we = take && (cnt_q == LEN_W'(i));
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)       cell_q <= 1'b0;
        else if (cell_we) cell_q <= bit_in;
      end
      assign frame[i] = cell_q;
    end
  endgenerate

  assign count = cnt_q;
  assign done  = done_q;
  assign dout  = dout_q;

endmodule

// File: rtl/cfg_serial_loader.sv
module cfg_serial_loader
  import cfg_loader_pkg::*;
#(
  parameter int FRAME_BITS     = 32,
  parameter int RATE_W         = 2,
  parameter int BASE_HALF_LOG2 = 3,
  parameter int SYNC_STAGES    = 2,
  localparam int LEN_W         = $clog2(FRAME_BITS + 1)
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic [2:0]            mode_sel,
  input  logic [LEN_W-1:0]      cfg_len,
  input  logic [RATE_W-1:0]     rate_code,
  input  logic                  rate_wr,
  input  logic                  cclk_in,
  input  logic                  din,
  output logic                  cclk_out,
  output logic                  dout,
  output logic                  done,
  output logic [FRAME_BITS-1:0] frame_data,
  output logic [LEN_W-1:0]      bit_count
);

  logic             armed;
  ld_mode_e         mode;
  logic [LEN_W-1:0] len;
  logic             ext_act, self_act;
  logic             ext_strobe, ext_bit;
  logic             self_rise;
  logic             strobe, bit_sel;

  cfg_mode_latch #(.FRAME_BITS(FRAME_BITS), .LEN_W(LEN_W)) u_mode (
    .clk(clk), .rst_n(rst_n), .mode_sel(mode_sel), .cfg_len(cfg_len),
    .armed(armed), .mode(mode), .len(len)
  );

  assign ext_act  = armed && (mode == LD_EXTCLK);
  assign self_act = armed && (mode == LD_SELFCLK);

  cfg_ext_sync #(.SYNC_STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .cclk_in(cclk_in), .din(din),
    .strobe(ext_strobe), .bit_out(ext_bit)
  );

  cfg_clk_div #(.RATE_W(RATE_W), .BASE_HALF_LOG2(BASE_HALF_LOG2)) u_div (
    .clk(clk), .rst_n(rst_n), .en(self_act), .rate_code(rate_code),
    .rate_wr(rate_wr), .cclk_out(cclk_out), .rise(self_rise)
  );

  always_comb begin
    strobe  = 1'b0;
    bit_sel = 1'b0;
    if (ext_act) begin
      strobe  = ext_strobe;
      bit_sel = ext_bit;
    end else if (self_act) begin
      strobe  = self_rise;
      bit_sel = din;
    end
  end

  cfg_frame_capture #(.FRAME_BITS(FRAME_BITS), .LEN_W(LEN_W)) u_cap (
    .clk(clk), .rst_n(rst_n), .en(armed), .strobe(strobe), .bit_in(bit_sel),
    .len(len), .frame(frame_data), .count(bit_count), .done(done), .dout(dout)
  );

endmodule

// File: rtl/cfg_serial_loader_chk.sv
module cfg_serial_loader_chk #(
  parameter int FRAME_BITS = 32,
  parameter int LEN_W      = 6
) (
  input logic                  clk,
  input logic                  rst_n,
  input logic                  self_act,
  input logic                  cclk_out,
  input logic                  dout,
  input logic                  done,
  input logic [FRAME_BITS-1:0] frame_data,
  input logic [LEN_W-1:0]      bit_count
);

  // R7
  done_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> done);

  // R3
  count_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bit_count != $past(bit_count)) |-> (bit_count == $past(bit_count) + LEN_W'(1)));

  // R6
  count_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    bit_count <= LEN_W'(FRAME_BITS));

  // R9
  clk_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !self_act |-> !cclk_out);

  // R8
  chain_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !done |-> !dout);

  // R8
  frame_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $past(done) |-> ($stable(frame_data) && $stable(bit_count)));

endmodule

bind cfg_serial_loader cfg_serial_loader_chk #(.FRAME_BITS(FRAME_BITS), .LEN_W(LEN_W)) chk_i (
  .clk(clk), .rst_n(rst_n), .self_act(self_act), .cclk_out(cclk_out), .dout(dout),
  .done(done), .frame_data(frame_data), .bit_count(bit_count)
);

// File: tb/cfg_serial_loader_tb_top.sv
module cfg_serial_loader_tb_top;

  localparam int CLK_PERIOD = 10;
  localparam int FB = 32;

  logic          clk = 1'b0;
  logic          rst_n;
  logic [2:0]    mode_sel;
  logic [5:0]    cfg_len;
  logic [1:0]    rate_code;
  logic          rate_wr;
  logic          cclk_in;
  logic          din;
  logic          cclk_out, dout, done;
  logic [FB-1:0] frame_data;
  logic [5:0]    bit_count;

  int checks = 0;
  int errors = 0;

  always #(CLK_PERIOD/2) clk = !clk;

  cfg_serial_loader dut_i (
    .clk(clk), .rst_n(rst_n), .mode_sel(mode_sel), .cfg_len(cfg_len),
    .rate_code(rate_code), .rate_wr(rate_wr), .cclk_in(cclk_in), .din(din),
    .cclk_out(cclk_out), .dout(dout), .done(done), .frame_data(frame_data),
    .bit_count(bit_count)
  );

  function automatic int exp_half(input int code);
    return (code >= 3) ? 1 : (8 >> code);
  endfunction

  task automatic check(input bit ok, input string req, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic do_reset(input logic [2:0] m, input logic [5:0] l);
    @(negedge clk);
    rst_n = 1'b0; mode_sel = m; cfg_len = l;
    rate_code = '0; rate_wr = 1'b0; cclk_in = 1'b0; din = 1'b0;
    repeat (3) @(negedge clk);
    check(done == 0 && dout == 0 && cclk_out == 0, "R1 flags in reset", {done, dout, cclk_out}, 0);
    check(frame_data == 0 && bit_count == 0, "R1 frame in reset", frame_data, 0);
    rst_n = 1'b1;
  endtask

  task automatic ext_bit(input logic b);
    cclk_in = 1'b0; din = b;
    repeat (3) @(negedge clk);
    cclk_in = 1'b1;
    repeat (4) @(negedge clk);
  endtask

  // Entered at a negedge where cclk_out is low; returns at the negedge that first sees it low again.
  task automatic self_bit(input logic b, input logic wr, input logic [1:0] code,
                          output int lo, output int hi);
    din = b; rate_code = code; rate_wr = wr;
    lo = 1; hi = 0;
    forever begin
      @(negedge clk); rate_wr = 1'b0;
      if (cclk_out == 1'b0) lo++; else break;
    end
    hi = 1;
    forever begin
      @(negedge clk);
      if (cclk_out == 1'b1) hi++; else break;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    logic [FB-1:0] exp_frame;
    logic [FB-1:0] bits;
    int lo, hi;
    void'($urandom(32'h1c0de5));
    rst_n = 1'b0; mode_sel = 3'b111; cfg_len = 6'd20;
    rate_code = '0; rate_wr = 1'b0; cclk_in = 1'b0; din = 1'b0;

    // ---------- externally clocked, length 20 ----------
    do_reset(3'b111, 6'd20);
    check(bit_count == 0 && done == 0, "R1 after release", bit_count, 0);
    bits = $urandom;
    exp_frame = '0;
    for (int k = 0; k < 20; k++) begin
      ext_bit(bits[k]);
      exp_frame[k] = bits[k];
      if (k == 3) mode_sel = 3'b000; // R2: late change must be ignored
      if (k == 18) check(done == 0, "R7 done before last bit", done, 0);
      if (k == 5) begin
        check(bit_count == 6, "R3 count mid-stream", bit_count, 6);
        check(cclk_out == 0, "R2 mode change ignored (no clock)", cclk_out, 0);
      end
    end
    check(done == 1, "R7 done at length", done, 1);
    check(bit_count == 20, "R3 final count", bit_count, 20);
    check(frame_data == exp_frame, "R3 frame contents", frame_data, exp_frame);
    for (int k = 0; k < 6; k++) begin
      logic cb;
      cb = 1'($urandom);
      ext_bit(cb);
      check(dout == cb, "R8 chain bit forwarded", dout, cb);
    end
    check(frame_data == exp_frame && bit_count == 20, "R8 frame frozen", frame_data, exp_frame);
    check(done == 1, "R7 done sticky", done, 1);

    // ---------- self-clocked, length 40 clamped to 32, rate raised ----------
    do_reset(3'b000, 6'd40);
    @(negedge clk);
    bits = $urandom;
    exp_frame = '0;
    for (int k = 0; k < FB; k++) begin
      self_bit(bits[k], k == 5, 2'd2, lo, hi);
      exp_frame[k] = bits[k];
      if (k == 1) begin
        check(hi == exp_half(0) && lo == exp_half(0), "R4 slowest default phase", {lo, hi}, 8);
      end
      if (k == 5) begin
        check(lo == exp_half(0), "R5 low phase keeps old rate", lo, exp_half(0));
        check(hi == exp_half(2), "R5 high phase takes new rate", hi, exp_half(2));
      end
      if (k == 6) check(lo == hi && hi == exp_half(2), "R5 equal phases after switch", {lo, hi}, 2);
      if (k == 30) check(done == 0, "R6 not done at 31 of 32", done, 0);
    end
    check(done == 1 && bit_count == FB, "R6 clamped length reached", bit_count, FB);
    check(frame_data == exp_frame, "R4 self-clocked frame", frame_data, exp_frame);
    for (int k = 0; k < 4; k++) begin
      logic cb;
      cb = 1'($urandom);
      self_bit(cb, 1'b0, 2'd0, lo, hi);
      check(dout == cb, "R8 self-clocked chain bit", dout, cb);
    end

    // ---------- idle code ----------
    do_reset(3'b010, 6'd4);
    for (int k = 0; k < 6; k++) begin
      ext_bit(1'b1);
      check(cclk_out == 0, "R9 no clock in idle", cclk_out, 0);
    end
    check(bit_count == 0 && done == 0, "R9 nothing captured in idle", bit_count, 0);

    $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule